// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is the one-shot countdown timer of a per-core interrupt controller. Software selects a clock divider through a configuration register and then arms the timer by writing a starting value to a load register. The timer counts that value down by one on every prescaled tick. When the value reaches zero it sends a pulse one clock wide to the interrupt logic and stops.

Software can read the number of whole ticks left at any time. It reads zero once the timer has stopped. Access is through a plain single-cycle register port with separate read and write strobes and a word address. The read data path is combinational by default. A parameter can insert a register into it.

The divider uses a compressed 3-bit code held in bits 3, 1 and 0 of the configuration word. That code plus one, taken modulo eight, is a shift amount. The divide ratio is two raised to that shift, so the ratios run from 2 up to 128, and the all-ones code gives 1.

Top module: `tmr_countdown`

## Requirements
- R1: Word address 0 is the divide setting. Its code is {wdata[3], wdata[1:0]}, and the ratio is 1 << ((code + 1) mod 8): code 000 gives 2, code 110 gives 128 and code 111 gives 1.
- R2: A write to address 0 keeps only bits 3, 1 and 0. A read of address 0 returns those bits in place, with every other bit zero.
- R3: A write to address 1 (the load register) loads the whole value and restarts the countdown. Any countdown already in progress is dropped without an expiry pulse. The prescaler restarts from zero.
- R4: If the load is sampled at clock edge k with value N > 0 and ratio D, then `expire` is high for exactly the one cycle after edge k + N·D.
- R5: A read of address 2 returns N − floor(m / D) during the cycles between edges k + m and k + m + 1, for m < N·D. The count decreases by exactly one per tick.
- R6: Writes to address 2 are ignored and do not disturb a running countdown.
- R7: Loading 0 stops the timer. Address 2 then reads 0 and no expiry pulse follows.
- R8: After expiry the count stays at 0 and no further pulse occurs until the next load.
- R9: After reset the divide setting is code 000 (ratio 2), the count is 0 and `expire` is low.
- R10: A read of address 1, or of any address other than 0 and 2, returns 0. With `rd_en` low, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (4) | Word address of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, 0 when no read is made |
| expire | output | 1 | Expiry pulse, high for one cycle |

## Verification
The bench walks every divide code and checks the expiry pulse at its exact cycle. A divider that was off by one, or a prescaler that was not cleared on load, would move the pulse by one tick or by one clock. It reads the count every cycle across tick boundaries, so a count rounded the wrong way shows up as a step in the wrong place. It reloads the timer while it is running, writes zero to stop it, and pokes the read-only count register in the middle of a run. A design that let the old countdown finish, pulsed on a zero load, or took the poked value would give a stray pulse or a bad count. Masking of the configuration word is checked with all-ones data and with random data.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // word offsets of the register port
   localparam int unsigned OFS_CFG  = 0;
   localparam int unsigned OFS_LOAD = 1;
   localparam int unsigned OFS_CUR  = 2;
   // compressed divide code and the widest shift it selects
   localparam int unsigned CODE_W   = 3;
   localparam int unsigned MAX_SHIFT = 7;
   localparam int unsigned PRE_W    = MAX_SHIFT;

   typedef logic [CODE_W-1:0] div_code_t;

   // shift amount is code + 1, wrapping in three bits
   function automatic logic [CODE_W-1:0] code_to_shift(input div_code_t c);
      return c + CODE_W'(1);
   endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int CNT_W    = 32,
   parameter bit READ_REG = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [CNT_W-1:0]         count,
   output tmr_pkg::div_code_t       code,
   output logic                     load,
   output logic [CNT_W-1:0]         load_val,
   output logic [DATA_W-1:0]        rdata
);
   import tmr_pkg::*;

   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFS_LOAD);
   localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(OFS_CUR);

   div_code_t          code_q;
   logic [DATA_W-1:0]  rd_mux;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (wr_en && addr == A_CFG) begin
         code_q <= {wdata[3], wdata[1:0]};
      end
   end

   assign code     = code_q;
   assign load     = wr_en && (addr == A_LOAD);
   assign load_val = wdata[CNT_W-1:0];

   always_comb begin
      rd_mux = '0;
      if (rd_en) begin
         if (addr == A_CFG) begin
            rd_mux = DATA_W'({code_q[2], 1'b0, code_q[1:0]});
         end else if (addr == A_CUR) begin
            rd_mux = DATA_W'(count);
         end
      end
   end

   generate
      if (READ_REG) begin : g_rd_flop
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign rdata = rd_q;
      end else begin : g_rd_comb
         assign rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               running,
   input  tmr_pkg::div_code_t code,
   output logic               tick
);
   import tmr_pkg::*;

   logic [PRE_W-1:0] pcnt_q;
   logic [PRE_W:0]   ratio;
   logic [PRE_W-1:0] last;

   assign ratio = (PRE_W+1)'(1) << code_to_shift(code);
   assign last  = PRE_W'(ratio - (PRE_W+1)'(1));
   // compare with >= so a smaller ratio chosen mid-period ends it at once
   assign tick  = running && !restart && (pcnt_q >= last);

   always_ff @(posedge clk) begin
      if (!rst_n || restart || !running || tick) begin
         pcnt_q <= '0;
      end else begin
         pcnt_q <= pcnt_q + PRE_W'(1);
      end
   end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             running,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;
   logic             exp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val;
         exp_q <= 1'b0;
      end else if (tick && cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
         exp_q <= (cnt_q == CNT_W'(1));
      end else begin
         exp_q <= 1'b0;
      end
   end

   assign count   = cnt_q;
   assign running = (cnt_q != '0);
   assign expire  = exp_q;
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int CNT_W    = 32,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              expire
);
   generate
      if (DATA_W < 4) begin : g_bad_data
         $error("DATA_W must hold the divide field");
      end
      if (CNT_W > DATA_W || CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be between 1 and DATA_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must reach three registers");
      end
   endgenerate

   tmr_pkg::div_code_t code;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] count_q;
   logic             running;
   logic             tick;

   tmr_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .READ_REG(READ_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .count(count_q), .code(code), .load(load),
      .load_val(load_val), .rdata(rdata)
   );

   tmr_prescaler u_pre (
      .clk(clk), .rst_n(rst_n), .restart(load), .running(running),
      .code(code), .tick(tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .tick(tick), .count(count_q), .running(running), .expire(expire)
   );
endmodule

// File: rtl/tmr_countdown_chk.sv
module tmr_countdown_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              expire,
   input logic [CNT_W-1:0]  count,
   input logic              tick
);
   logic wr_load;
   assign wr_load = wr_en && (addr == ADDR_W'(tmr_pkg::OFS_LOAD));

   // R4: pulse lasts a single cycle
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);

   // R8: pulse only with count parked at zero
   a_r8_expire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> count == '0);

   // R3: load takes the written value
   a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      wr_load |=> count == $past(wdata[CNT_W-1:0]));

   // R7: zero load never pulses
   a_r7_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_load && wdata[CNT_W-1:0] == '0) |=> !expire);

   // R6: without a load the count never rises
   a_r6_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_load |=> count <= $past(count));

   // R5: each tick removes exactly one
   a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_load && tick && count != '0) |=> count == $past(count) - CNT_W'(1));
endmodule

bind tmr_countdown tmr_countdown_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .expire(expire), .count(count_q), .tick(tick)
);

// File: tb/tmr_countdown_test.sv
module tmr_countdown_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        expire;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_countdown uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .expire(expire)
   );

   task automatic check(input bit ok, input string req, input longint act,
                        input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int ratio_of(input logic [3:0] c);
      int sh;
      sh = (int'({c[3], c[1:0]}) + 1) % 8;
      return 1 << sh;
   endfunction

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      rd_en = 1'b0;
   endtask

   // load n under divide setting c, then watch count and pulse every cycle
   task automatic run(input logic [3:0] c, input int n, input int poke_t,
                      input string tag);
      int span, r, first_t;
      longint act, exp;
      bit err;
      r = ratio_of(c);
      span = n * r;
      err = 1'b0; act = 0; exp = 0; first_t = -1;
      wr(4'd0, {28'd0, c});
      wr(4'd1, n);
      rd_en = 1'b1; addr = 4'd2;
      for (int t = 0; t <= span + 24; t++) begin
         longint ec;
         bit ee;
         #1;
         ee = (n != 0) && (t == span);
         ec = (t < span) ? longint'(n - t / r) : 0;
         if (!err && (expire !== ee || rdata !== ec[31:0])) begin
            err = 1'b1; first_t = t;
            act = {rdata, 3'b0, expire}; exp = {ec[31:0], 3'b0, ee};
         end
         if (t == poke_t) begin
            wr_en = 1'b1; wdata = 32'h5A5A_0003;
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
      end
      wr_en = 1'b0; rd_en = 1'b0;
      if (err) $display("  %s mismatch at cycle %0d (code %0h n %0d)", tag, first_t, c, n);
      check(!err, tag, act, exp);
   endtask

   initial begin
      logic [31:0] d;
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      check(expire === 1'b0, "R9 expire after reset", expire, 0);
      rd(4'd0, d); check(d === 32'h0, "R9 divide after reset", d, 0);
      rd(4'd2, d); check(d === 32'h0, "R9 count after reset", d, 0);

      // R2 masking of the divide word
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, d); check(d === 32'hB, "R2 all-ones divide", d, 32'hB);
      for (int i = 0; i < 4; i++) begin
         logic [31:0] v;
         v = $urandom;
         wr(4'd0, v);
         rd(4'd0, d); check(d === (v & 32'hB), "R2 random divide", d, v & 32'hB);
      end

      // R10 load register and unused address read 0, idle read 0
      wr(4'd1, 32'd77);
      rd(4'd1, d); check(d === 32'h0, "R10 load reads zero", d, 0);
      rd(4'd3, d); check(d === 32'h0, "R10 unused address", d, 0);
      @(negedge clk); rd_en = 1'b0; addr = 4'd2;
      #1 check(rdata === 32'h0, "R10 idle read", rdata, 0);

      // R1 R4 R5 every divide code
      for (int c = 0; c < 8; c++) begin
         logic [3:0] cf;
         cf = {c[2], 1'b0, c[1:0]};
         run(cf, 3, -1, "R1 R4 R5 divide code");
      end

      // R3 reload while running drops the old countdown
      wr(4'd0, 32'h7);
      wr(4'd1, 32'd50);
      repeat (10) @(negedge clk);
      run(4'h7, 5, -1, "R3 reload mid-run");

      // R6 write to current count during a run
      run(4'h0, 10, 4, "R6 poke read-only count");

      // R7 zero load stops a running timer
      wr(4'd1, 32'd40);
      repeat (5) @(negedge clk);
      run(4'h7, 0, -1, "R7 zero load");

      // R8 hold at zero checked by the tail of each run; explicit long idle
      run(4'h3, 2, -1, "R8 hold after expiry");

      // R4 R5 random divide settings and counts
      for (int i = 0; i < 10; i++) begin
         logic [3:0] cf;
         cf = 4'($urandom);
         run(cf, 1 + int'($urandom % 16), -1, "R4 R5 random");
      end

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule